// File: doc/BRIEF.md
# Dual Signed Halfword Multiply Add/Subtract Unit

This unit takes two operand words and treats each as a pair of two's-complement signed halfwords. It forms two exact signed products. It then either adds them or subtracts the upper-lane product from the lower-lane product, and presents the wrapped result one clock later. An exchange control swaps the two halfwords of the second operand before the products are formed, so the unit can compute cross products as well as straight ones.

A sticky flag records signed overflow of the sum. For halfwords this happens only when both lanes multiply the most negative value by itself. The flag holds until a dedicated clear input is pulsed. A valid strobe travels with each result. The halfword width is a parameter and defaults to 16, which gives 32-bit operands and results.

Top module: `dual_half_mac`

## Requirements
- R1: Each operand splits into a bottom signed halfword at bits [HALF_W-1:0] and a top signed halfword at bits [2*HALF_W-1:HALF_W]. Each product is the exact 2*HALF_W-bit signed product of two halfwords.
- R2: With exch_i=0 the two products are a.bottom*b.bottom (bottom product) and a.top*b.top (top product).
- R3: With exch_i=1 the halves of op_b_i are swapped first, so the bottom product is a.bottom*b.top and the top product is a.top*b.bottom.
- R4: With sub_i=0 result_o is the sum of the two products, wrapped to 2*HALF_W bits with no saturation. In the single overflow case the result is 0x80000000.
- R5: With sub_i=1 result_o is the bottom product minus the top product, wrapped to 2*HALF_W bits.
- R6: ovf_o goes high in the cycle after a valid add whose signed sum overflows, and rises for no other reason.
- R7: ovf_o is sticky and is not cleared by later non-overflowing operations. A cycle with clr_flag_i=1 clears it, unless that same cycle carries a valid overflowing add, in which case the flag stays set.
- R8: A subtract never sets ovf_o.
- R9: valid_o equals valid_i delayed by one clock. result_o loads only on cycles with valid_i=1 and holds otherwise.
- R10: While rst_ni is low, result_o, valid_o and ovf_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and controls are valid this cycle |
| op_a_i | input | 2*HALF_W | First operand, two signed halfwords |
| op_b_i | input | 2*HALF_W | Second operand, two signed halfwords |
| sub_i | input | 1 | 0: add products, 1: bottom minus top |
| exch_i | input | 1 | Swap the halfwords of op_b_i before multiplying |
| clr_flag_i | input | 1 | Clear the sticky overflow flag |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 2*HALF_W | Registered result |
| ovf_o | output | 1 | Sticky add-overflow flag |

## Verification
The bench builds the unit with the default HALF_W of 16. At that width the single overflow corner, both lanes at -32768 times -32768, can be driven directly next to its neighbours: one lane at the corner, exchange pairing the corner halves, and the same operands in subtract mode. A 64-bit reference model in the bench makes every sign combination and every wrap of the 32-bit result checkable against exact arithmetic. The bench drives a clear in the same cycle as an overflowing add to exercise the rule that the set wins.

// File: rtl/dhm_pkg.sv
package dhm_pkg;
  typedef enum logic {
    CMB_ADD = 1'b0,
    CMB_SUB = 1'b1
  } cmb_op_e;

  localparam int unsigned LANES    = 2;
  localparam int unsigned LANE_BOT = 0;
  localparam int unsigned LANE_TOP = 1;
endpackage

// File: rtl/dhm_operand_sel.sv
module dhm_operand_sel #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0]                     op_a_i,
  input  logic [WORD_W-1:0]                     op_b_i,
  input  logic                                  exch_i,
  output logic [dhm_pkg::LANES-1:0][HALF_W-1:0] a_half_o,
  output logic [dhm_pkg::LANES-1:0][HALF_W-1:0] b_half_o
);
  for (genvar g = 0; g < int'(dhm_pkg::LANES); g++) begin : g_lane
    localparam int unsigned OWN = g * HALF_W;
    localparam int unsigned OPP = (dhm_pkg::LANES - 1 - g) * HALF_W;
    assign a_half_o[g] = op_a_i[OWN +: HALF_W];
    // exchange pairs each first-operand half with the opposite second-operand half
    assign b_half_o[g] = exch_i ? op_b_i[OPP +: HALF_W] : op_b_i[OWN +: HALF_W];
  end
endmodule

// File: rtl/dhm_lane_mul.sv
module dhm_lane_mul #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned PROD_W = 2 * HALF_W
) (
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  output logic [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] a_ext, b_ext, prod;

  assign a_ext  = {{HALF_W{a_i[HALF_W-1]}}, a_i};
  assign b_ext  = {{HALF_W{b_i[HALF_W-1]}}, b_i};
  assign prod   = a_ext * b_ext;
  assign prod_o = prod;
endmodule

// File: rtl/dhm_combine.sv
module dhm_combine #(
  parameter int unsigned PROD_W = 32
) (
  input  logic [PROD_W-1:0]     prod_bot_i,
  input  logic [PROD_W-1:0]     prod_top_i,
  input  dhm_pkg::cmb_op_e      op_i,
  output logic [PROD_W-1:0]     res_o,
  output logic                  add_ovf_o
);
  import dhm_pkg::*;

  logic [PROD_W-1:0] sum, diff;

  assign sum  = prod_bot_i + prod_top_i;
  assign diff = prod_bot_i - prod_top_i;

  always_comb begin
    res_o     = sum;
    add_ovf_o = 1'b0;
    unique case (op_i)
      CMB_ADD: begin
        res_o     = sum;
        add_ovf_o = (prod_bot_i[PROD_W-1] == prod_top_i[PROD_W-1]) &&
                    (sum[PROD_W-1] != prod_bot_i[PROD_W-1]);
      end
      CMB_SUB: begin
        res_o     = diff;
        add_ovf_o = 1'b0;  // difference of two halfword products always fits
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dual_half_mac.sv
module dual_half_mac #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  input  logic              sub_i,
  input  logic              exch_i,
  input  logic              clr_flag_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] result_o,
  output logic              ovf_o
);
  import dhm_pkg::*;

  localparam logic [WORD_W-1:0] CORNER_PROD = WORD_W'(1) << (WORD_W - 2);

  logic [LANES-1:0][HALF_W-1:0] a_half, b_half;
  logic [LANES-1:0][WORD_W-1:0] prod;
  logic [WORD_W-1:0]            res_d;
  logic                         add_ovf;
  cmb_op_e                      op_sel;

  dhm_operand_sel #(.HALF_W(HALF_W)) u_sel (
    .op_a_i  (op_a_i),
    .op_b_i  (op_b_i),
    .exch_i  (exch_i),
    .a_half_o(a_half),
    .b_half_o(b_half)
  );

  for (genvar g = 0; g < int'(LANES); g++) begin : g_mul
    dhm_lane_mul #(.HALF_W(HALF_W)) u_mul (
      .a_i   (a_half[g]),
      .b_i   (b_half[g]),
      .prod_o(prod[g])
    );
  end

  assign op_sel = sub_i ? CMB_SUB : CMB_ADD;

  dhm_combine #(.PROD_W(WORD_W)) u_cmb (
    .prod_bot_i(prod[LANE_BOT]),
    .prod_top_i(prod[LANE_TOP]),
    .op_i      (op_sel),
    .res_o     (res_d),
    .add_ovf_o (add_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      ovf_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
      // a set in the clearing cycle wins
      ovf_o <= (ovf_o & ~clr_flag_i) | (valid_i & add_ovf);
    end
  end

  p_valid_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_flag_i) |=> ovf_o);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_flag_i && !(valid_i && add_ovf)) |=> !ovf_o);
  p_rise_only_ovf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_o && !(valid_i && add_ovf)) |=> !ovf_o);
  p_ovf_corner_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_ovf |-> (prod[LANE_BOT] == CORNER_PROD && prod[LANE_TOP] == CORNER_PROD));
  p_no_sub_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sub_i) |=> (ovf_o == $past(ovf_o && !clr_flag_i)));
  p_ovf_result_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && add_ovf) |=> (result_o == (WORD_W'(1) << (WORD_W - 1))));
endmodule

// File: tb/tb_dual_half_mac.sv
`timescale 1ns/1ps
module tb_dual_half_mac;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 32;

  typedef struct {
    logic [WORD_W-1:0] res;
    logic              flg;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid_i = 1'b0, sub_i = 1'b0, exch_i = 1'b0, clr_i = 1'b0;
  logic [WORD_W-1:0] op_a = '0, op_b = '0;
  logic              valid_o, ovf_o;
  logic [WORD_W-1:0] result_o;

  int   errors = 0, checks = 0;
  exp_t q[$];
  logic flag_model = 1'b0;
  logic [WORD_W-1:0] last_res = '0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  dual_half_mac #(.HALF_W(HALF_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_a_i(op_a), .op_b_i(op_b),
    .sub_i(sub_i), .exch_i(exch_i), .clr_flag_i(clr_i),
    .valid_o(valid_o), .result_o(result_o), .ovf_o(ovf_o)
  );

  task automatic check(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
                                input logic sub, input logic exch,
                                output logic [WORD_W-1:0] r, output logic ovf);
    longint ab, at, bb, bt, pb, pt, v;
    ab = longint'($signed(a[15:0]));
    at = longint'($signed(a[31:16]));
    bb = exch ? longint'($signed(b[31:16])) : longint'($signed(b[15:0]));
    bt = exch ? longint'($signed(b[15:0])) : longint'($signed(b[31:16]));
    pb = ab * bb;
    pt = at * bt;
    v  = sub ? pb - pt : pb + pt;
    r  = v[31:0];
    ovf = !sub && (v > 64'sd2147483647 || v < -64'sd2147483648);
  endfunction

  task automatic drive(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
                       input logic sub, input logic exch, input logic clr);
    exp_t e;
    logic ovf;
    @(negedge clk);
    op_a = a; op_b = b; sub_i = sub; exch_i = exch; clr_i = clr; valid_i = 1'b1;
    model(a, b, sub, exch, e.res, ovf);
    flag_model = (flag_model & ~clr) | ovf;
    e.flg = flag_model;
    e.tag = sub ? "R5" : (exch ? "R3" : (ovf ? "R4/R6" : "R2/R4"));
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0; clr_i = 1'b0;
      op_a = $urandom; op_b = $urandom; sub_i = $urandom; exch_i = $urandom;
    end
  endtask

  task automatic clear_flag();
    @(negedge clk);
    valid_i = 1'b0; clr_i = 1'b1;
    flag_model = 1'b0;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: scoreboard compare
  always @(posedge clk) begin
    #1;
    if (rst_n && valid_o) begin
      if (q.size() == 0) begin
        check("R9 unexpected valid_o", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, result_o, e.res);
        check("R6/R7 flag", {31'd0, ovf_o}, {31'd0, e.flg});
        last_res = e.res;
      end
    end
  end

  initial begin
    #(5.0 * 50000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    valid_i = 1'b1; op_a = 32'h7fff_7fff; op_b = 32'h8000_8000;
    repeat (3) @(negedge clk);
    check("R10 valid_o in reset", {31'd0, valid_o}, 32'd0);
    check("R10 result_o in reset", result_o, 32'd0);
    check("R10 ovf_o in reset", {31'd0, ovf_o}, 32'd0);
    valid_i = 1'b0;
    rst_n = 1'b1;
    idle(2);

    // R1 R2 straight pairing with mixed signs
    drive(32'h0003_fffe, 32'h0005_0007, 1'b0, 1'b0, 1'b0); // -2*7 + 3*5 = 1
    drive(32'h7fff_7fff, 32'h7fff_7fff, 1'b0, 1'b0, 1'b0);
    drive(32'h8000_0001, 32'h7fff_ffff, 1'b0, 1'b0, 1'b0);
    // R3 exchange pairing
    drive(32'h0002_0003, 32'h0005_0007, 1'b0, 1'b1, 1'b0); // 3*5 + 2*7 = 29
    drive(32'h8000_7fff, 32'h8000_0001, 1'b0, 1'b1, 1'b0);
    // R5 subtract, both pairings
    drive(32'h0002_0003, 32'h0005_0007, 1'b1, 1'b0, 1'b0); // 21 - 10 = 11
    drive(32'h0002_0003, 32'h0005_0007, 1'b1, 1'b1, 1'b0); // 15 - 14 = 1
    drive(32'h7fff_8000, 32'h8000_8000, 1'b1, 1'b0, 1'b0);
    // R8 the overflow corner operands in subtract mode
    drive(32'h8000_8000, 32'h8000_8000, 1'b1, 1'b0, 1'b0);
    drive(32'h8000_8000, 32'h8000_8000, 1'b1, 1'b1, 1'b0);
    // one lane at the corner: no overflow
    drive(32'h8000_8000, 32'h0001_8000, 1'b0, 1'b0, 1'b0);
    idle(2);
    check("R8 no flag after corner subtract", {31'd0, ovf_o}, 32'd0);
    // R9 hold: result unchanged through idle cycles with changing inputs
    idle(3);
    check("R9 result holds while idle", result_o, last_res);

    // R4 R6 overflow corner: 0x80000000
    drive(32'h8000_8000, 32'h8000_8000, 1'b0, 1'b0, 1'b0);
    // R7 sticky across normal ops
    drive(32'h0001_0001, 32'h0001_0001, 1'b0, 1'b0, 1'b0);
    drive(32'h0001_0001, 32'h0001_0001, 1'b1, 1'b0, 1'b0);
    idle(2);
    check("R7 flag sticky", {31'd0, ovf_o}, 32'd1);
    clear_flag();
    check("R7 flag cleared", {31'd0, ovf_o}, 32'd0);
    // R3 R6 exchange overflow corner
    drive(32'h8000_8000, 32'h8000_8000, 1'b0, 1'b1, 1'b0);
    idle(1);
    // R7 clear together with overflowing add: set wins
    drive(32'h8000_8000, 32'h8000_8000, 1'b0, 1'b0, 1'b1);
    idle(2);
    check("R7 set wins over clear", {31'd0, ovf_o}, 32'd1);
    // R7 clear together with non-overflowing add: cleared
    drive(32'h0004_0004, 32'h0004_0004, 1'b0, 1'b0, 1'b1);
    idle(2);
    check("R7 clear with plain op", {31'd0, ovf_o}, 32'd0);

    // mixed stream, back to back and gapped
    for (int i = 0; i < 400; i++) begin
      logic [WORD_W-1:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 37 == 0) a = 32'h8000_8000;
      if (i % 41 == 0) b = 32'h8000_8000;
      drive(a, b, 1'(($urandom % 3) == 0), 1'($urandom), 1'(($urandom % 29) == 0));
      if (i % 7 == 0) idle(1);
    end
    idle(3);
    check("R9 queue drained", q.size(), 32'd0);
    finish_run();
  end
endmodule